// File: doc/BRIEF.md
# Dual-Reload PWM Timer with Periodic On-Counter

This block produces one PWM waveform from a single 16-bit down-counter that alternates between a high phase and a low phase. Each phase has its own reload value, so the high time and the low time are set on their own. A second 16-bit down-counter runs next to it and gives a one-clock event pulse each time it expires. A divide-by-10 prescaler can be placed in front of that second counter only.

Both counters advance on a common tick. The tick is either every system clock or a low-power tick enable that is generated outside the block. A small register port holds the three reload values. A read of a reload address returns the live count instead of the stored reload, so software can watch the counters run. An optional output mode replaces the steady high level with a square wave at half the system clock rate.

Top module: `pwm_dual_reload_timer`

## Requirements
- R1: After reset all three reload registers and both counters are 0, and `pwm_out` and `on_evt` are 0. Every read address returns 0.
- R2: While `run_en` is 0 both counters and the prescaler are held at 0, `pwm_out` is 0 and `on_evt` is 0. Reload writes are still accepted.
- R3: With `fast_sel`=1 every system clock is a tick and `lp_tick` has no effect. With `fast_sel`=0 a tick happens only on clocks where `lp_tick` is 1.
- R4: On the first tick after enable the main counter loads the high reload H and the phase goes high. On every tick it counts down. A tick at count 0 switches phase and loads the other reload (low reload L, or H again). The high phase therefore lasts H+1 ticks and the low phase lasts L+1 ticks.
- R5: With `toggle_mode`=0, `pwm_out` is a steady 1 during the high phase. With `toggle_mode`=1 it is 1 on the first clock of the high phase and then flips on every clock. In both modes it is 0 during the low phase.
- R6: The address map is: `addr`=0 high reload, `addr`=1 low reload, `addr`=2 on-counter reload, `addr`=3 unused. A read of address 0 or 1 returns the live main count. A read of address 2 returns the live on-count. A read of address 3 returns 0.
- R7: The on-counter loads its reload R on its first advance from 0. It then counts down once per advance, and `on_evt` is 1 for exactly the clock after the advance that takes the count from 1 to 0. This gives one event every R+1 advances. With R=0 there is never an event.
- R8: With `div_bypass`=1 the on-counter advances on every tick. With `div_bypass`=0 it advances only on every tenth tick after enable (ticks 9, 19, ... counting from 0). The main counter is not affected by the prescaler.
- R9: A reload written while the timer runs leaves the current count alone. The new value is used at the next load of that counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (fast) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_tick | input | 1 | Low-power tick enable, one clock wide |
| run_en | input | 1 | 1 runs the timer, 0 holds it cleared |
| fast_sel | input | 1 | 1 ticks every clock, 0 ticks on `lp_tick` |
| div_bypass | input | 1 | 1 feeds the tick straight to the on-counter, 0 divides it by 10 |
| toggle_mode | input | 1 | 1 outputs half-clock toggling during the high phase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (live counts for counter addresses) |
| pwm_out | output | 1 | PWM output |
| on_evt | output | 1 | On-counter expiry pulse |

## Verification
The bench checks the exact clock on which each phase changes and the count read back at that clock. A design that is off by one in its reload arithmetic would stretch or shorten each phase by one tick, or would show a count one higher than the bench expects. The bench also changes the high reload in the middle of a phase. A design that loads the new value at once would cut that phase short. With an event period of 0, a design that reloads and pulses at 0 would fire on every advance instead of never. With the divide-by-10 prescaler active, the bench checks that the main counter keeps its speed while the event moves to every tenth tick. A design that also divided the main counter, or miscounted the prescaler, would move the event or the phase edges by many clocks.

// File: rtl/pwm_dual_reload_timer.sv
module pwm_dual_reload_timer #(
  parameter int CW  = 16,
  parameter int DIV = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_tick,
  input  logic          run_en,
  input  logic          fast_sel,
  input  logic          div_bypass,
  input  logic          toggle_mode,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          pwm_out,
  output logic          on_evt
);
  localparam int DW = $clog2(DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [CW-1:0] hi_rl, lo_rl, on_rl;
  logic [CW-1:0] cnt, on_cnt;
  logic [DW-1:0] div_cnt;
  logic          phase_high, tog;

  wire tick    = fast_sel | lp_tick;
  wire on_tick = tick & (div_bypass | (div_cnt == DIV_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_rl <= '0;
      lo_rl <= '0;
      on_rl <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0:    hi_rl <= wdata;
        2'd1:    lo_rl <= wdata;
        2'd2:    on_rl <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      phase_high <= 1'b0;
      tog        <= 1'b0;
    end else if (!run_en) begin
      cnt        <= '0;
      phase_high <= 1'b0;
      tog        <= 1'b0;
    end else begin
      tog <= phase_high ? ~tog : 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          phase_high <= ~phase_high;
          cnt        <= phase_high ? lo_rl : hi_rl;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      on_cnt  <= '0;
      on_evt  <= 1'b0;
    end else if (!run_en) begin
      div_cnt <= '0;
      on_cnt  <= '0;
      on_evt  <= 1'b0;
    end else begin
      if (tick) div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
      on_evt <= on_tick && (on_cnt == CW'(1));
      if (on_tick) on_cnt <= (on_cnt == '0) ? on_rl : on_cnt - 1'b1;
    end
  end

  assign pwm_out = phase_high & (~toggle_mode | ~tog);

  always_comb begin
    case (addr)
      2'd0, 2'd1: rdata = cnt;
      2'd2:       rdata = on_cnt;
      default:    rdata = '0;
    endcase
  end

  // R2
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!pwm_out && !on_evt && cnt == '0 && on_cnt == '0));

  // R7
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |=> !on_evt);

  // R5
  toggle_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && phase_high && $past(phase_high) &&
     toggle_mode && $past(toggle_mode)) |-> (pwm_out != $past(pwm_out)));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && $past(cnt) != '0 && cnt != $past(cnt))
      |-> (cnt == $past(cnt) - 1'b1));

  // R8
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= DIV_LAST);
endmodule

// File: tb/pwm_dual_reload_timer_test.sv
module pwm_dual_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, lp_tick = 0, run_en = 0, fast_sel = 0;
  logic div_bypass = 0, toggle_mode = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic pwm_out, on_evt;

  int checks = 0, errors = 0;

  typedef struct {
    logic        pwm;
    logic        evt;
    logic [15:0] rd;
    string       tag;
  } item_t;
  item_t sbq[$];

  pwm_dual_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .run_en(run_en),
    .fast_sel(fast_sel), .div_bypass(div_bypass), .toggle_mode(toggle_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .on_evt(on_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push(input logic p, input logic e, input int rd, input string tag);
    item_t it;
    it.pwm = p; it.evt = e; it.rd = 16'(rd); it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (pwm_out !== it.pwm || on_evt !== it.evt || rdata !== it.rd) begin
        errors++;
        $display("FAIL %s: got pwm=%b evt=%b rd=%0d, expected pwm=%b evt=%b rd=%0d",
                 it.tag, pwm_out, on_evt, rdata, it.pwm, it.evt, it.rd);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    addr = 2'(a); wdata = 16'(d); wr_en = 1;
    step();
    wr_en = 0;
  endtask

  // Driver: configure, run ncyc clocks, push the value the requirements predict
  task automatic run_cfg(input int h, input int l, input int r, input bit fast,
                         input bit byp, input bit mode, input int lp_per,
                         input int raddr, input int ncyc, input string tag);
    int t = -1, n = -1, j = 0;
    bit prev_high = 0;
    wr(0, h); wr(1, l); wr(2, r);
    fast_sel = fast; div_bypass = byp; toggle_mode = mode; addr = 2'(raddr);
    run_en = 1;
    for (int k = 0; k < ncyc; k++) begin
      bit tk, otk, high, p, e;
      int pos, mcnt, ocnt;
      lp_tick = (k % lp_per == 0);
      tk = fast || lp_tick;
      step();
      otk = 0;
      if (tk) begin
        t++;
        otk = byp || (t % 10 == 9);
        if (otk) n++;
      end
      pos  = t % (h + l + 2);
      high = (pos < h + 1);
      mcnt = high ? h - pos : l - (pos - h - 1);
      if (high && !prev_high) j = 0; else if (high) j++;
      prev_high = high;
      p = high && (!mode || (j % 2 == 0));
      e = otk && r > 0 && (n % (r + 1) == r);
      ocnt = (n < 0) ? 0 : r - (n % (r + 1));
      push(p, e, (raddr == 2) ? ocnt : mcnt, tag);
    end
    run_en = 0; lp_tick = 0;
    step();
    push(0, 0, 0, "R2 cleared after disable");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    // R1 reset state on all read addresses
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      checks++;
      if (pwm_out !== 0 || on_evt !== 0 || rdata !== 0) begin
        errors++;
        $display("FAIL R1 addr %0d: got pwm=%b evt=%b rd=%0d, expected 0 0 0",
                 a, pwm_out, on_evt, rdata);
      end
    end
    rst_n = 1;
    step();
    // R2: writes while disabled leave counters at 0
    wr(0, 7);
    addr = 0; push(0, 0, 0, "R2 held while disabled");
    step();

    // R4 R6 R7 R3: fast ticks, lp_tick toggling is ignored, read low-reload address
    run_cfg(3, 2, 4, 1, 1, 0, 2, 1, 30, "R4/R6/R7 fast mode0");
    // R5: toggle mode, R7 with period 0 gives no event
    run_cfg(4, 3, 0, 1, 1, 1, 1, 0, 30, "R5/R7 toggle mode, no event");
    // R3: low-power tick every third clock, read on-counter
    run_cfg(2, 1, 2, 0, 1, 0, 3, 2, 40, "R3/R7 lp tick");
    // R8: divide-by-10 on on-counter only
    run_cfg(0, 0, 1, 1, 0, 0, 1, 2, 60, "R8 divided on-counter");
    run_cfg(2, 1, 1, 1, 0, 0, 1, 0, 30, "R8 main counter undivided");

    // R9: change high reload mid-phase
    wr(0, 3); wr(1, 2); wr(2, 0);
    fast_sel = 1; div_bypass = 1; toggle_mode = 0; addr = 0;
    run_en = 1;
    step(); push(1, 0, 3, "R9 P0");
    step(); push(1, 0, 2, "R9 P1");
    wdata = 1; wr_en = 1;
    step(); wr_en = 0; push(1, 0, 1, "R9 current count kept");
    step(); push(1, 0, 0, "R9 P3");
    step(); push(0, 0, 2, "R9 low");
    step(); step(); push(0, 0, 0, "R9 P6");
    step(); push(1, 0, 1, "R9 new high reload loaded");
    step(); push(1, 0, 0, "R9 P8");
    step(); push(0, 0, 2, "R9 shortened high phase");
    run_en = 0;
    step(); push(0, 0, 0, "R2 disable mid-run");
    addr = 3;
    run_en = 1;
    step(); push(1, 0, 0, "R6 addr 3 reads 0");
    run_en = 0;
    step(); step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule